// File: doc/BRIEF.md
# Strip Readout Peak-Channel Sequencer

This block is the digital control section of a 16-channel strip readout front end. It combines two discriminated external trigger lines into one internal trigger, using either an OR or an AND that a register selects. A rising edge of that trigger starts a scan. The scan steps an analog multiplexer index across the held channels in turn. For each channel it issues a start pulse to an external 8-bit converter and waits for the converter's done strobe. One converter LSB represents 40 fC.

Each converted value is compared against a programmable digital threshold. A value below the threshold is stored as zero. While the scan runs, the block keeps a running record of the channel holding the largest charge. When the last channel has been converted, it raises a data-ready flag. A host reads the per-channel charges, the peak channel index and the peak charge over a parallel bus with active-low chip-select, read and write strobes. The same bus writes the threshold and trigger-mode registers. A clock-enable output is high only while a scan or a pending readout is in progress, so that the internal clock can be gated off when the block is idle.

Top module: `strip_peak_seq`

## Requirements
- R1: The internal trigger is trig_a_i OR trig_b_i when mode register bit 0 is 0, and trig_a_i AND trig_b_i when it is 1. A scan starts only on a rising edge of the internal trigger.
- R2: A scan converts channels 0 to 15 in ascending order. For each channel, mux_sel_o shows the channel index, adc_start_o pulses for exactly one cycle, and the block waits for adc_done_i before moving on.
- R3: The value converted for channel n is readable at local address n (0x00 to 0x0F).
- R4: A converted value strictly below the threshold register (local 0x12) is stored as zero. A value equal to or above the threshold is stored unchanged.
- R5: Local address 0x10 returns the index of the channel with the largest stored charge, and local 0x11 returns that charge. When several channels tie, the lowest index is reported.
- R6: If every stored value of a scan is zero, the peak index reads 0x1F and the peak charge reads 0.
- R7: data_ready_o rises after the last channel is converted. It falls after the host reads local 0x10.
- R8: A trigger edge that arrives during a scan, or while data_ready_o is high, is ignored and starts no conversion.
- R9: clk_en_o is high exactly while a scan is in progress or data_ready_o is high.
- R10: The block answers the bus only when bus_cs_ni is low and bus_addr_i[10:6] equals base_i; the local address is bus_addr_i[5:0]. A write with bus_wr_ni low sets the threshold (0x12) or the mode (0x13, bit 0). During a matching read, bus_oe_o is high and bus_rdata_o carries the register. Otherwise bus_oe_o is low and bus_rdata_o is 0.
- R11: After reset, the threshold is 0, the mode is OR, data_ready_o is low, every channel charge is 0, and the peak reads 0x1F with a charge of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_a_i | input | 1 | First discriminated trigger line |
| trig_b_i | input | 1 | Second discriminated trigger line |
| adc_start_o | output | 1 | One-cycle conversion start pulse |
| adc_done_i | input | 1 | Converter result valid strobe |
| adc_data_i | input | 8 | Converter result |
| mux_sel_o | output | 4 | Analog multiplexer channel index |
| clk_en_o | output | 1 | Internal clock enable |
| data_ready_o | output | 1 | Scan results waiting to be read |
| bus_cs_ni | input | 1 | Chip select, active low |
| bus_rd_ni | input | 1 | Read strobe, active low |
| bus_wr_ni | input | 1 | Write strobe, active low |
| bus_addr_i | input | 11 | Bus address |
| base_i | input | 5 | Chip base address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| bus_oe_o | output | 1 | Read data drive enable |

## Verification
The assertions check the following on every cycle: the start pulse lasts one cycle, no conversion starts while results are pending, sub-threshold samples land as zero, the peak charge never falls within a scan, the ready flag drops after a peak-index read, and the bus stays silent unless chip select and base match. Some properties need whole scenarios, and only the bench shows them. These are the exact peak index under ties and equal-to-threshold samples, the 0x1F marker when every channel is suppressed, the choice between OR and AND triggering, and the count of conversions when extra triggers land mid-scan or during a pending readout.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_WAIT,
    S_DONE
  } scan_state_e;
endpackage

// File: rtl/trig_combine.sv
module trig_combine (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_a_i,
  input  logic trig_b_i,
  input  logic and_mode_i,
  output logic trig_rise_o
);
  logic trig, trig_q;

  assign trig = and_mode_i ? (trig_a_i & trig_b_i) : (trig_a_i | trig_b_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig;

  assign trig_rise_o = trig & ~trig_q;

  p_and_needs_both_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_rise_o && and_mode_i) |-> (trig_a_i && trig_b_i));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import strip_pkg::*;
#(
  parameter int N_CH  = 16,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_ready_i,
  input  logic [DW-1:0]    thr_i,
  input  logic             adc_done_i,
  input  logic [DW-1:0]    adc_data_i,
  output logic             adc_start_o,
  output logic [IDX_W-1:0] mux_sel_o,
  output logic [DW-1:0]    chg_o [N_CH],
  output logic [IDX_W:0]   peak_idx_o,
  output logic [DW-1:0]    peak_chg_o,
  output logic             ready_o,
  output logic             busy_o
);
  localparam logic [IDX_W:0]   NO_PEAK = '1;
  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(N_CH - 1);

  scan_state_e     state_q;
  logic [IDX_W-1:0] ch_q;
  logic [DW-1:0]   chg_q [N_CH];
  logic [IDX_W:0]  pk_idx_q;
  logic [DW-1:0]   pk_chg_q;
  logic            ready_q;
  logic [DW-1:0]   sample;

  assign sample = (adc_data_i < thr_i) ? '0 : adc_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ch_q     <= '0;
      pk_idx_q <= NO_PEAK;
      pk_chg_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      if (clr_ready_i) ready_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i && !ready_q) begin
          ch_q     <= '0;
          pk_idx_q <= NO_PEAK;
          pk_chg_q <= '0;
          state_q  <= S_START;
        end
        S_START: state_q <= S_WAIT;
        S_WAIT: if (adc_done_i) begin
          // strict compare keeps the lowest index on ties
          if (sample > pk_chg_q) begin
            pk_idx_q <= {1'b0, ch_q};
            pk_chg_q <= sample;
          end
          if (ch_q == LAST_CH) state_q <= S_DONE;
          else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= S_START;
          end
        end
        S_DONE: begin
          ready_q <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_chg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chg_q[g] <= '0;
      else if (state_q == S_WAIT && adc_done_i && ch_q == IDX_W'(g)) chg_q[g] <= sample;
    assign chg_o[g] = chg_q[g];
  end

  assign adc_start_o = (state_q == S_START);
  assign mux_sel_o   = ch_q;
  assign peak_idx_o  = pk_idx_q;
  assign peak_chg_o  = pk_chg_q;
  assign ready_o     = ready_q;
  assign busy_o      = (state_q != S_IDLE);

  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
  p_thr_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && adc_done_i && adc_data_i < thr_i) |=> chg_q[$past(ch_q)] == '0);
  p_peak_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && $past(state_q) == S_WAIT) |-> pk_chg_q >= $past(pk_chg_q));
  p_ready_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ready_i && state_q != S_DONE) |=> !ready_q);
  p_no_conv_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> !adc_start_o);
endmodule

// File: rtl/host_regs.sv
module host_regs #(
  parameter int N_CH  = 16,
  parameter int DW    = 8,
  parameter int AW    = 11,
  parameter int BW    = 5,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [BW-1:0]    base_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    chg_i [N_CH],
  input  logic [IDX_W:0]   peak_idx_i,
  input  logic [DW-1:0]    peak_chg_i,
  output logic [DW-1:0]    rdata_o,
  output logic             oe_o,
  output logic [DW-1:0]    thr_o,
  output logic             and_mode_o,
  output logic             clr_ready_o
);
  localparam int LW = AW - BW;
  localparam logic [LW-1:0] A_PK_IDX = LW'(N_CH);
  localparam logic [LW-1:0] A_PK_CHG = LW'(N_CH + 1);
  localparam logic [LW-1:0] A_THR    = LW'(N_CH + 2);
  localparam logic [LW-1:0] A_MODE   = LW'(N_CH + 3);

  logic          sel, rd_act, rd_q, wr_act;
  logic [LW-1:0] la;
  logic [DW-1:0] rmux;

  assign la     = addr_i[LW-1:0];
  assign sel    = !cs_ni && (addr_i[AW-1:LW] == base_i);
  assign rd_act = sel && !rd_ni;
  assign wr_act = sel && !wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      thr_o      <= '0;
      and_mode_o <= 1'b0;
      rd_q       <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (wr_act && la == A_THR)  thr_o      <= wdata_i;
      if (wr_act && la == A_MODE) and_mode_o <= wdata_i[0];
    end

  assign clr_ready_o = rd_act && !rd_q && la == A_PK_IDX;

  always_comb begin
    rmux = '0;
    if (la < LW'(N_CH)) rmux = chg_i[la[IDX_W-1:0]];
    else if (la == A_PK_IDX) rmux = DW'(peak_idx_i);
    else if (la == A_PK_CHG) rmux = peak_chg_i;
    else if (la == A_THR)    rmux = thr_o;
    else if (la == A_MODE)   rmux = DW'(and_mode_o);
  end

  assign oe_o    = rd_act;
  assign rdata_o = rd_act ? rmux : '0;

  p_no_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || addr_i[AW-1:LW] != base_i) |-> (!oe_o && rdata_o == '0));
endmodule

// File: rtl/strip_peak_seq.sv
module strip_peak_seq #(
  parameter int N_CH  = 16,
  parameter int DW    = 8,
  parameter int AW    = 11,
  parameter int BW    = 5,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_a_i,
  input  logic             trig_b_i,
  output logic             adc_start_o,
  input  logic             adc_done_i,
  input  logic [DW-1:0]    adc_data_i,
  output logic [IDX_W-1:0] mux_sel_o,
  output logic             clk_en_o,
  output logic             data_ready_o,
  input  logic             bus_cs_ni,
  input  logic             bus_rd_ni,
  input  logic             bus_wr_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [BW-1:0]    base_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             bus_oe_o
);
  logic           trig_rise, and_mode, clr_ready, busy;
  logic [DW-1:0]  thr, peak_chg;
  logic [IDX_W:0] peak_idx;
  logic [DW-1:0]  chg [N_CH];

  trig_combine u_trig (
    .clk_i, .rst_ni, .trig_a_i, .trig_b_i,
    .and_mode_i (and_mode),
    .trig_rise_o(trig_rise)
  );

  scan_ctrl #(.N_CH(N_CH), .DW(DW), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni,
    .start_i    (trig_rise),
    .clr_ready_i(clr_ready),
    .thr_i      (thr),
    .adc_done_i, .adc_data_i, .adc_start_o, .mux_sel_o,
    .chg_o      (chg),
    .peak_idx_o (peak_idx),
    .peak_chg_o (peak_chg),
    .ready_o    (data_ready_o),
    .busy_o     (busy)
  );

  host_regs #(.N_CH(N_CH), .DW(DW), .AW(AW), .BW(BW), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .cs_ni      (bus_cs_ni),
    .rd_ni      (bus_rd_ni),
    .wr_ni      (bus_wr_ni),
    .addr_i     (bus_addr_i),
    .base_i,
    .wdata_i    (bus_wdata_i),
    .chg_i      (chg),
    .peak_idx_i (peak_idx),
    .peak_chg_i (peak_chg),
    .rdata_o    (bus_rdata_o),
    .oe_o       (bus_oe_o),
    .thr_o      (thr),
    .and_mode_o (and_mode),
    .clr_ready_o(clr_ready)
  );

  assign clk_en_o = busy | data_ready_o;

  p_gate_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (!adc_start_o && !data_ready_o));
endmodule

// File: tb/strip_peak_seq_tb.sv
module strip_peak_seq_tb;
  localparam logic [4:0] BASE = 5'h0B;

  typedef struct packed {
    logic [127:0] samp;
    logic [7:0]   thr;
    logic         and_m;
    logic [4:0]   idx;
    logic [7:0]   pk;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{128'h968C_8278_6E64_5A50_463C_3228_1E14_0A00, 8'h00, 1'b0, 5'd15,   8'h96},
    '{128'h1E1E_1E1E_1E1E_1E1E_1E1E_C81E_1E1E_1E1E, 8'h00, 1'b1, 5'd5,    8'hC8},
    '{128'h0A0A_0A0A_0A0A_B40A_0A0A_0A0A_B40A_0A0A, 8'h05, 1'b0, 5'd3,    8'hB4},
    '{128'h1414_1414_1414_1414_1414_1414_1414_1414, 8'h32, 1'b1, 5'h1F,   8'h00},
    '{128'h3131_3131_3131_3131_3231_3131_3131_3131, 8'h32, 1'b0, 5'd7,    8'h32},
    '{128'h8080_8080_8080_8080_8080_8080_8080_80FF, 8'h40, 1'b1, 5'd0,    8'hFF}
  };

  logic clk = 0, rst_ni = 0;
  logic trig_a = 0, trig_b = 0, adc_done = 0;
  logic [7:0] adc_data = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [10:0] addr = 0;
  logic [7:0] wdata = 0;
  logic adc_start, clk_en, data_ready, oe;
  logic [3:0] mux_sel;
  logic [7:0] rdata;

  int errors = 0, checks = 0, n_start = 0;
  logic [7:0] vals [16];
  int pend_cnt = 0;
  logic [3:0] pend_sel = 0;

  always #4 clk = ~clk;

  strip_peak_seq u_dut (
    .clk_i(clk), .rst_ni, .trig_a_i(trig_a), .trig_b_i(trig_b),
    .adc_start_o(adc_start), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .mux_sel_o(mux_sel), .clk_en_o(clk_en), .data_ready_o(data_ready),
    .bus_cs_ni(cs_n), .bus_rd_ni(rd_n), .bus_wr_ni(wr_n), .bus_addr_i(addr),
    .base_i(BASE), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_oe_o(oe)
  );

  // converter model: result two cycles after the start pulse
  always @(negedge clk) begin
    if (adc_done) adc_done = 0;
    if (adc_start) begin
      pend_sel = mux_sel;
      pend_cnt = 2;
    end else if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        adc_data = vals[pend_sel];
        adc_done = 1;
      end
    end
  end

  always @(posedge clk) if (adc_start) n_start++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] b, logic [5:0] la, logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = {b, la}; wdata = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(logic [4:0] b, logic [5:0] la, output logic [7:0] d, output logic o);
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = {b, la};
    @(negedge clk);
    d = rdata; o = oe;
    cs_n = 1; rd_n = 1;
  endtask

  task automatic pulse_trig(logic a, logic b);
    @(negedge clk);
    trig_a = a; trig_b = b;
    repeat (2) @(negedge clk);
    trig_a = 0; trig_b = 0;
  endtask

  task automatic wait_ready(string req);
    int n = 0;
    while (!data_ready && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(req, data_ready, 1);
  endtask

  task automatic load(logic [127:0] s);
    for (int i = 0; i < 16; i++) vals[i] = s[i*8 +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic o;
    int s0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R11 reset state
    chk("R11 data_ready", data_ready, 0);
    chk("R11 clk_en", clk_en, 0);
    bus_rd(BASE, 6'h12, d, o); chk("R11 thr", d, 0);
    bus_rd(BASE, 6'h13, d, o); chk("R11 mode", d, 0);
    bus_rd(BASE, 6'h10, d, o); chk("R11 peak idx", d, 8'h1F);
    bus_rd(BASE, 6'h11, d, o); chk("R11 peak chg", d, 0);
    bus_rd(BASE, 6'h04, d, o); chk("R11 chan", d, 0);

    // table of scenarios: R2 R3 R4 R5 R6 R7 R9
    foreach (VECS[v]) begin
      load(VECS[v].samp);
      bus_wr(BASE, 6'h12, VECS[v].thr);
      bus_wr(BASE, 6'h13, {7'b0, VECS[v].and_m});
      s0 = n_start;
      pulse_trig(1'b1, VECS[v].and_m);
      chk("R9 clk_en during scan", clk_en, 1);
      wait_ready("R7 ready after scan");
      chk("R2 sixteen conversions", n_start - s0, 16);
      for (int i = 0; i < 16; i++) begin
        bus_rd(BASE, 6'(i), d, o);
        chk("R3 R4 channel value", d, (vals[i] < VECS[v].thr) ? 0 : vals[i]);
      end
      bus_rd(BASE, 6'h11, d, o); chk("R5 R6 peak charge", d, VECS[v].pk);
      chk("R9 clk_en while pending", clk_en, 1);
      bus_rd(BASE, 6'h10, d, o); chk("R5 R6 peak index", d, {3'b0, VECS[v].idx});
      @(negedge clk);
      chk("R7 ready cleared", data_ready, 0);
      chk("R9 clk_en idle", clk_en, 0);
    end

    // R1: AND mode, only one line high -> no scan
    bus_wr(BASE, 6'h13, 8'h01);
    s0 = n_start;
    pulse_trig(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R1 AND single line", n_start - s0, 0);
    chk("R1 AND no clk_en", clk_en, 0);
    // R1: OR mode, second line alone starts a scan
    bus_wr(BASE, 6'h13, 8'h00);
    load(VECS[0].samp);
    bus_wr(BASE, 6'h12, 8'h00);
    s0 = n_start;
    pulse_trig(1'b0, 1'b1);
    // R8: extra trigger mid-scan
    repeat (6) @(negedge clk);
    pulse_trig(1'b1, 1'b0);
    wait_ready("R1 OR line b");
    chk("R8 mid-scan trigger ignored", n_start - s0, 16);
    // R8: trigger while results pending
    load(VECS[5].samp);
    s0 = n_start;
    pulse_trig(1'b1, 1'b1);
    repeat (40) @(negedge clk);
    chk("R8 pending trigger ignored", n_start - s0, 0);
    bus_rd(BASE, 6'h11, d, o); chk("R8 peak kept", d, 8'h96);

    // R10: wrong base ignored for read and write
    bus_rd(5'h03, 6'h11, d, o);
    chk("R10 foreign read oe", o, 0);
    chk("R10 foreign read data", d, 0);
    bus_wr(5'h03, 6'h12, 8'h77);
    bus_rd(BASE, 6'h12, d, o);
    chk("R10 foreign write thr", d, 0);
    chk("R10 matching read oe", o, 1);
    bus_wr(BASE, 6'h12, 8'h5A);
    bus_rd(BASE, 6'h12, d, o); chk("R10 thr write", d, 8'h5A);
    // foreign read of 0x10 must not clear ready
    bus_rd(5'h03, 6'h10, d, o);
    @(negedge clk);
    chk("R7 foreign read keeps ready", data_ready, 1);
    bus_rd(BASE, 6'h10, d, o);
    chk("R5 peak idx ramp", d, 15);
    @(negedge clk);
    chk("R7 ready cleared again", data_ready, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule